// File: doc/BRIEF.md
# Instruction Sampling Profiler

This unit profiles a processor by following single instructions rather than counting events. After software arms it, it counts fetched instructions down from a reload value. That value is a programmable base period plus a small pseudo-random offset, so the choice of sample does not fall into step with loop lengths. When the count is used up, the unit tags the next fetched instruction as the sample and takes its program counter.

While the tagged instruction travels down the pipeline, the unit collects what happens to it. This covers an instruction-cache miss, a wrong branch prediction, a trap and its type, and the retire delay. Every pipeline report arrives with a tag bit, and only reports that carry the tag are taken. When the tagged instruction leaves the pipeline, either retired or aborted, the collected values are copied into held result registers and an interrupt is raised.

The results stay frozen until software writes the re-arm strobe. That strobe clears the interrupt and the valid bit, and it starts a new count. Only one sample can be tagged or held at any time.

Top module: `instr_sample_profiler`

## Requirements
- R1: After reset, `smp_valid` and `irq` are 0, and no fetch is tagged until `sw_rearm` has been pulsed.
- R2: A `sw_rearm` pulse loads the skip count S = `cfg_period` + (low 4 bits of a 16-bit LFSR). The LFSR resets to 0xACE1. It steps once on each re-arm, after its low bits have been used. Each step is a right shift, and when the bit shifted out is 1 the result is XORed with 0xB400. The fetch numbered S (counting from 0) after the re-arm is tagged: `fetch_tag` is 1 in that cycle.
- R3: Only cycles with `fetch_valid` = 1 are counted. `fetch_tag` is never 1 in a cycle without a fetch.
- R4: After a tag, `fetch_tag` stays 0 until the next `sw_rearm`. This holds while the sample is in flight and while its results are held.
- R5: `smp_pc` reports the `fetch_pc` of the tagged fetch.
- R6: `smp_icmiss` and `smp_mispred` are 1 exactly when a matching event with its tag bit set arrived between the tag cycle (exclusive) and the exit cycle (inclusive). Events that do not carry the tag bit are ignored.
- R7: `smp_trap` reports whether a tagged trap arrived in the same window. `smp_trap_type` holds the type of the first such trap, or 0 when there was none.
- R8: A tagged exit (`exit_ev` and `exit_tag`) ends the sample. From the next cycle on, `smp_valid` and `irq` are 1 and `smp_retired` holds `exit_retired`. Exits without the tag bit are ignored.
- R9: `smp_delay` is the number of cycles from the tag cycle to the exit cycle, which is at least 1. It saturates at 2^DLY_W-1.
- R10: `sw_rearm` clears `smp_valid` and `irq` on the next cycle. A sample still in flight is dropped and reports nothing.
- R11: While results are held, the result outputs stay fixed, and later events, exits and fetches have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_period | input | CNT_W | Base skip count, sampled at re-arm |
| sw_rearm | input | 1 | Software write strobe: acknowledge and re-arm |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| fetch_pc | input | PC_W | PC of the fetched instruction |
| fetch_tag | output | 1 | This cycle's fetch is the sample |
| miss_ev | input | 1 | Instruction-cache miss report |
| miss_tag | input | 1 | Miss report belongs to the sample |
| misp_ev | input | 1 | Branch mispredict report |
| misp_tag | input | 1 | Mispredict report belongs to the sample |
| trap_ev | input | 1 | Trap report |
| trap_tag | input | 1 | Trap report belongs to the sample |
| trap_type | input | TRAP_W | Type of the reported trap |
| exit_ev | input | 1 | An instruction leaves the pipeline |
| exit_tag | input | 1 | Leaving instruction is the sample |
| exit_retired | input | 1 | 1 = retired, 0 = aborted |
| smp_valid | output | 1 | Held results are valid |
| smp_pc | output | PC_W | Sample PC |
| smp_icmiss | output | 1 | Sample missed in the instruction cache |
| smp_mispred | output | 1 | Sample's branch was mispredicted |
| smp_trap | output | 1 | Sample trapped |
| smp_trap_type | output | TRAP_W | First trap type of the sample |
| smp_retired | output | 1 | Sample retired (1) or aborted (0) |
| smp_delay | output | DLY_W | Cycles from tag to exit, saturating |
| irq | output | 1 | Interrupt request |

## Verification
`fetch_tag` is combinational and is due in the same cycle as the fetch that is tagged. The bench therefore drives each fetch on the falling edge and samples the tag shortly afterwards. Held results and `irq` are registered, so they are due one edge after the tagged exit or after `sw_rearm`, and the bench checks them at the next falling edge. The bench keeps its own LFSR model, stepped once per re-arm, to predict the fetch that gets tagged. It predicts the delay from the number of cycles it lets pass between tag and exit.

// File: rtl/instr_sample_profiler.sv
module instr_sample_profiler #(
  parameter int PC_W      = 32,
  parameter int TRAP_W    = 4,
  parameter int DLY_W     = 8,
  parameter int CNT_W     = 16,
  parameter int OFS_W     = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [15:0] LFSR_MASK = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic              sw_rearm,
  input  logic              fetch_valid,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              fetch_tag,
  input  logic              miss_ev,
  input  logic              miss_tag,
  input  logic              misp_ev,
  input  logic              misp_tag,
  input  logic              trap_ev,
  input  logic              trap_tag,
  input  logic [TRAP_W-1:0] trap_type,
  input  logic              exit_ev,
  input  logic              exit_tag,
  input  logic              exit_retired,
  output logic              smp_valid,
  output logic [PC_W-1:0]   smp_pc,
  output logic              smp_icmiss,
  output logic              smp_mispred,
  output logic              smp_trap,
  output logic [TRAP_W-1:0] smp_trap_type,
  output logic              smp_retired,
  output logic [DLY_W-1:0]  smp_delay,
  output logic              irq
);
  localparam int RW = CNT_W + 1;
  localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};

  typedef enum logic [1:0] {S_OFF, S_COUNT, S_FLIGHT, S_HELD} st_t;

  st_t               st;
  logic [RW-1:0]     cnt;
  logic [15:0]       lfsr;
  logic [PC_W-1:0]   w_pc;
  logic              w_miss, w_misp, w_trap;
  logic [TRAP_W-1:0] w_ttype;
  logic [DLY_W-1:0]  dly;

  wire [15:0]   lfsr_nx = (lfsr >> 1) ^ (lfsr[0] ? LFSR_MASK : 16'h0000);
  wire [RW-1:0] reload  = {1'b0, cfg_period} + RW'(lfsr[OFS_W-1:0]);

  wire in_flight = (st == S_FLIGHT) && !sw_rearm;
  wire miss_hit  = in_flight && miss_ev && miss_tag;
  wire misp_hit  = in_flight && misp_ev && misp_tag;
  wire trap_hit  = in_flight && trap_ev && trap_tag;
  wire exit_hit  = in_flight && exit_ev && exit_tag;

  assign fetch_tag = (st == S_COUNT) && !sw_rearm && fetch_valid && (cnt == '0);
  assign irq       = smp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_OFF;
      cnt           <= '0;
      lfsr          <= LFSR_SEED;
      w_pc          <= '0;
      w_miss        <= 1'b0;
      w_misp        <= 1'b0;
      w_trap        <= 1'b0;
      w_ttype       <= '0;
      dly           <= '0;
      smp_valid     <= 1'b0;
      smp_pc        <= '0;
      smp_icmiss    <= 1'b0;
      smp_mispred   <= 1'b0;
      smp_trap      <= 1'b0;
      smp_trap_type <= '0;
      smp_retired   <= 1'b0;
      smp_delay     <= '0;
    end else if (sw_rearm) begin
      st        <= S_COUNT;
      cnt       <= reload;
      lfsr      <= lfsr_nx;
      smp_valid <= 1'b0;
      w_miss    <= 1'b0;
      w_misp    <= 1'b0;
      w_trap    <= 1'b0;
      w_ttype   <= '0;
      dly       <= '0;
    end else begin
      case (st)
        S_COUNT: begin
          if (fetch_valid) begin
            if (cnt == '0) begin
              st   <= S_FLIGHT;
              w_pc <= fetch_pc;
              dly  <= DLY_W'(1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        S_FLIGHT: begin
          if (miss_hit) w_miss <= 1'b1;
          if (misp_hit) w_misp <= 1'b1;
          if (trap_hit && !w_trap) begin
            w_trap  <= 1'b1;
            w_ttype <= trap_type;
          end
          if (exit_hit) begin
            st            <= S_HELD;
            smp_valid     <= 1'b1;
            smp_pc        <= w_pc;
            smp_icmiss    <= w_miss | miss_hit;
            smp_mispred   <= w_misp | misp_hit;
            smp_trap      <= w_trap | trap_hit;
            smp_trap_type <= w_trap ? w_ttype : (trap_hit ? trap_type : '0);
            smp_retired   <= exit_retired;
            smp_delay     <= dly;
          end else if (dly != DLY_MAX) begin
            dly <= dly + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF) |-> !fetch_tag && !smp_valid);

  p_tag_needs_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_tag |-> fetch_valid);

  p_single_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_tag |=> !fetch_tag);

  p_no_tag_while_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !fetch_tag);

  p_pc_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_tag && !sw_rearm) |=> (w_pc == $past(fetch_pc)));

  p_exit_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> smp_valid && irq);

  p_delay_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && !exit_hit && dly == DLY_MAX) |=> (dly == DLY_MAX));

  p_delay_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_delay != '0));

  p_rearm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rearm |=> !smp_valid && !irq);

  p_held_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !sw_rearm) |=> smp_valid && $stable(smp_pc) && $stable(smp_delay)
      && $stable(smp_trap_type) && $stable(smp_retired) && $stable(smp_icmiss));
endmodule

// File: tb/tb_instr_sample_profiler.sv
module tb_instr_sample_profiler;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_period;
  logic        sw_rearm, fetch_valid, fetch_tag;
  logic [31:0] fetch_pc;
  logic        miss_ev, miss_tag, misp_ev, misp_tag, trap_ev, trap_tag;
  logic [3:0]  trap_type;
  logic        exit_ev, exit_tag, exit_retired;
  logic        smp_valid, smp_icmiss, smp_mispred, smp_trap, smp_retired, irq;
  logic [31:0] smp_pc;
  logic [3:0]  smp_trap_type;
  logic [7:0]  smp_delay;

  instr_sample_profiler dut (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] m = 16'hACE1;

  function automatic logic [15:0] lstep(input logic [15:0] s);
    lstep = (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    sw_rearm = 0; fetch_valid = 0; fetch_pc = '0;
    miss_ev = 0; miss_tag = 0; misp_ev = 0; misp_tag = 0;
    trap_ev = 0; trap_tag = 0; trap_type = '0;
    exit_ev = 0; exit_tag = 0; exit_retired = 0;
  endtask

  task automatic rearm(input int per, output int skip);
    idle();
    cfg_period = 16'(per);
    sw_rearm = 1;
    skip = per + int'(m[3:0]);
    m = lstep(m);
    @(negedge clk);
    sw_rearm = 0;
    chk("R10 valid cleared", smp_valid, 0);
    chk("R10 irq cleared", irq, 0);
  endtask

  task automatic sample(input int per, input int delay, input bit miss, input bit misp,
                        input bit trap, input logic [3:0] tt, input bit ret,
                        input bit gaps, input logic [31:0] base);
    int skip;
    logic [31:0] epc;
    logic [7:0]  ed;
    rearm(per, skip);
    for (int i = 0; i <= skip; i++) begin
      if (gaps) begin
        fetch_valid = 0;
        #1 chk("R3 idle cycle not counted", fetch_tag, 0);
        @(negedge clk);
      end
      fetch_valid = 1;
      fetch_pc = base + 32'(i);
      #1 chk("R2 tag position", fetch_tag, (i == skip));
      @(negedge clk);
    end
    for (int k = 1; k <= delay; k++) begin
      fetch_valid = 1;
      fetch_pc = base + 32'd1000 + 32'(k);
      miss_ev = 1; miss_tag = miss && (k == delay);
      misp_ev = 1; misp_tag = misp && (k == 1);
      trap_ev = 1;
      trap_tag = trap && ((k == delay) || (k == ((delay > 1) ? delay - 1 : 1)));
      trap_type = (k == delay && delay > 1) ? ~tt : tt;
      exit_ev = 1; exit_tag = (k == delay);
      exit_retired = (k == delay) ? ret : ~ret;
      #1 chk("R4 no tag in flight", fetch_tag, 0);
      if (k <= 3) chk("R8 untagged exit ignored", smp_valid, 0);
      @(negedge clk);
    end
    idle();
    epc = base + 32'(skip);
    ed  = (delay > 255) ? 8'd255 : 8'(delay);
    chk("R8 valid", smp_valid, 1);
    chk("R8 irq", irq, 1);
    chk("R8 outcome", smp_retired, ret);
    chk("R5 pc", smp_pc, epc);
    chk("R6 icache miss", smp_icmiss, miss);
    chk("R6 mispredict", smp_mispred, misp);
    chk("R7 trap flag", smp_trap, trap);
    chk("R7 first trap type", smp_trap_type, trap ? tt : 4'd0);
    chk("R9 delay", smp_delay, ed);
    for (int j = 0; j < 3; j++) begin
      fetch_valid = 1; fetch_pc = 32'hFFFF_0000;
      miss_ev = 1; miss_tag = 1; misp_ev = 1; misp_tag = 1;
      trap_ev = 1; trap_tag = 1; trap_type = ~tt;
      exit_ev = 1; exit_tag = 1; exit_retired = ~ret;
      #1 chk("R4 no tag while held", fetch_tag, 0);
      @(negedge clk);
      chk("R11 pc held", smp_pc, epc);
      chk("R11 delay held", smp_delay, ed);
      chk("R11 outcome held", smp_retired, ret);
      chk("R11 miss held", smp_icmiss, miss);
    end
    idle();
  endtask

  initial begin
    int skip;
    int pers[5] = '{0, 1, 2, 5, 17};
    int dlys[5] = '{1, 2, 5, 40, 300};
    idle();
    cfg_period = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", smp_valid, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1;
    for (int i = 0; i < 20; i++) begin
      fetch_valid = 1; fetch_pc = 32'(i);
      #1 chk("R1 no tag before arming", fetch_tag, 0);
      @(negedge clk);
    end
    for (int p = 0; p < 5; p++)
      for (int d = 0; d < 5; d++) begin
        int n = p * 5 + d;
        sample(pers[p], dlys[d], n[0], n[1], n[2], 4'(n + 3), n[0] ^ n[3],
               n[1] ^ n[2], 32'h1000_0000 + 32'(n) * 32'h100);
      end
    rearm(3, skip);
    for (int i = 0; i <= skip; i++) begin
      fetch_valid = 1; fetch_pc = 32'h2000 + 32'(i);
      #1 chk("R2 tag position before drop", fetch_tag, (i == skip));
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    rearm(40, skip);
    exit_ev = 1; exit_tag = 1; exit_retired = 1;
    @(negedge clk);
    idle();
    chk("R10 dropped sample reports nothing", smp_valid, 0);
    sample(2, 4, 1, 1, 1, 4'h9, 1, 0, 32'h3000_0000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule